// File: doc/BRIEF.md
# Programme Fetch Sequencer

This block walks an external programme source through an eight-step cycle. Seven steps are fetch periods, and each one pulls a single address strobe low so that the source can present the matching word. The eighth step is an idle gap. The programme clock arrives as an ordinary input. The block samples it on a fast system clock and detects its edges there. While the enable is high, each rising edge of the programme clock moves the sequence on by one step. Each falling edge inside a fetch period produces a one-clock load pulse, which carries the index of that period, for the registers downstream. Periods 0 to 5 carry number digits 0 to 5. Period 6 carries the configuration word: modulus, half-step enable and offset, and divider ratio select.

The sequence can run without stopping or be halted when asked. If the enable is low at a rising edge of the programme clock, the cycle is broken off and the strobes all go high. The next falling edge then parks the sequencer in the configuration period, period 6. While parked, a data-valid input loads configuration on every system clock in which it is high, with no need to toggle the programme clock. A rising edge with the enable high again leaves the parked state and re-enters the normal cycle at its idle step.

Top module: `prog_fetch_seq`

## Requirements
- R1: After reset the sequencer is in fetch period 0, so `fetch_n` = 7'b1111110, and `load_pulse` is low.
- R2: A programme-clock edge takes effect on the (SYNC_STAGES+1)th system clock edge after it is applied. While running with `pe_in` high, each rising edge moves the step index 0→1→…→7→0. In step k<7 only `fetch_n[k]` is low.
- R3: Step 7 is idle. All seven strobes are high, and a falling programme-clock edge produces no load.
- R4: A falling programme-clock edge in running fetch period k gives `load_pulse` high for one system clock, with `load_idx` = k, on the clock after that edge is acted on.
- R5: A rising programme-clock edge with `pe_in` low while running breaks off the cycle. All strobes go high and no load follows.
- R6: After such a break, the next falling programme-clock edge parks the sequencer in period 6 (`fetch_n` = 7'b0111111). That edge produces no load.
- R7: While parked, programme-clock edges with `pe_in` low keep the sequencer parked and produce no load.
- R8: While parked, each system clock with `cfg_valid` high gives a load with `load_idx` = 6 on the next clock. When not parked, `cfg_valid` has no effect.
- R9: While parked, a rising programme-clock edge with `pe_in` high moves the sequencer to idle step 7, and the normal cycle follows. A `cfg_valid` sampled in that same clock still produces its period-6 load.
- R10: A load caused by a programme-clock falling edge is exactly one system clock wide, however long the programme clock stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pc_in | input | 1 | Programme clock, sampled on `clk` |
| pe_in | input | 1 | Programme enable; low requests a stop |
| cfg_valid | input | 1 | Configuration data valid while parked |
| fetch_n | output | 7 | Active-low fetch address strobes, bit k for period k |
| load_pulse | output | 1 | One-clock load strobe |
| load_idx | output | 3 | Fetch period of the current load |

## Verification
Two events can land on the same system clock. One is a data-valid configuration load while parked. The other is the resume step caused by a rising programme-clock edge with the enable high. The bench provokes this by holding `cfg_valid` high across the whole resume edge. Its reference model then expects an index-6 load in the very clock that the strobes switch to all high, and none afterwards. The break-off edge and the parking edge are also probed at a programme-clock falling edge, where the model expects the parking to happen with no load.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int FETCH_SLOTS = 7;
  localparam int IDX_W       = $clog2(FETCH_SLOTS + 1);
  localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(FETCH_SLOTS);
  localparam logic [IDX_W-1:0] CFG_IDX  = IDX_W'(FETCH_SLOTS - 1);

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_ARMED  = 2'd1,
    MODE_PARKED = 2'd2
  } seq_mode_t;
endpackage

// File: rtl/pfs_edge.sv
module pfs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pc_in,
  output logic pc_rise,
  output logic pc_fall
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pc_rise = sync_q[STAGES-1] & ~prev_q;
  assign pc_fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pfs_state.sv
module pfs_state
  import pfs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pc_rise,
  input  logic                   pc_fall,
  input  logic                   pe_in,
  output logic [IDX_W-1:0]       cur_idx,
  output logic                   parked,
  output logic [FETCH_SLOTS-1:0] fetch_n
);
  logic [IDX_W-1:0] idx_q, idx_d;
  seq_mode_t        mode_q, mode_d;
  logic             state_en;

  assign state_en = pc_rise | pc_fall;

  always_comb begin
    idx_d  = idx_q;
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (pc_rise) begin
          if (pe_in) begin
            idx_d = idx_q + 1'b1;
          end else begin
            idx_d  = IDLE_IDX;
            mode_d = MODE_ARMED;
          end
        end
      end
      MODE_ARMED: begin
        if (pc_fall) begin
          idx_d  = CFG_IDX;
          mode_d = MODE_PARKED;
        end
      end
      MODE_PARKED: begin
        if (pc_rise && pe_in) begin
          idx_d  = IDLE_IDX;
          mode_d = MODE_RUN;
        end
      end
      default: begin
        idx_d  = IDLE_IDX;
        mode_d = MODE_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mode_q <= MODE_RUN;
    end else if (state_en) begin
      idx_q  <= idx_d;
      mode_q <= mode_d;
    end
  end

  for (genvar k = 0; k < FETCH_SLOTS; k++) begin : g_strobe
    assign fetch_n[k] = ~(idx_q == IDX_W'(k));
  end

  assign cur_idx = idx_q;
  assign parked  = (mode_q == MODE_PARKED);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~fetch_n) <= 1);

  // R2
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && pc_rise && pe_in) |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

  // R5
  break_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && pc_rise && !pe_in) |=> (&fetch_n && !parked));

  // R6
  park_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ARMED && pc_fall) |=> (parked && !fetch_n[FETCH_SLOTS-1]));

  // R9
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && pc_rise && pe_in) |=> (!parked && &fetch_n));
endmodule

// File: rtl/pfs_load.sv
module pfs_load
  import pfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc_fall,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             parked,
  input  logic             cfg_valid,
  output logic             load_pulse,
  output logic [IDX_W-1:0] load_idx
);
  logic             ld_d, ld_q;
  logic [IDX_W-1:0] li_d, li_q;

  always_comb begin
    if (parked) begin
      ld_d = cfg_valid;
      li_d = CFG_IDX;
    end else begin
      ld_d = pc_fall && (cur_idx != IDLE_IDX);
      li_d = cur_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q <= 1'b0;
    end else begin
      ld_q <= ld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      li_q <= '0;
    end else if (ld_d) begin
      li_q <= li_d;
    end
  end

  assign load_pulse = ld_q;
  assign load_idx   = li_q;

  // R3
  idle_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!parked && cur_idx == IDLE_IDX) |=> !load_pulse);

  // R4
  fall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!parked && pc_fall && cur_idx != IDLE_IDX) |=> (load_pulse && load_idx == $past(cur_idx)));

  // R8
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && cfg_valid) |=> (load_pulse && load_idx == CFG_IDX));
endmodule

// File: rtl/prog_fetch_seq.sv
module prog_fetch_seq
  import pfs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc_in,
  input  logic             pe_in,
  input  logic             cfg_valid,
  output logic [6:0]       fetch_n,
  output logic             load_pulse,
  output logic [2:0]       load_idx
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             pc_rise, pc_fall;
  logic [IDX_W-1:0] cur_idx;
  logic             parked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  pfs_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pc_in   (pc_in),
    .pc_rise (pc_rise),
    .pc_fall (pc_fall)
  );

  pfs_state u_state (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pc_rise (pc_rise),
    .pc_fall (pc_fall),
    .pe_in   (pe_in),
    .cur_idx (cur_idx),
    .parked  (parked),
    .fetch_n (fetch_n)
  );

  pfs_load u_load (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pc_fall    (pc_fall),
    .cur_idx    (cur_idx),
    .parked     (parked),
    .cfg_valid  (cfg_valid),
    .load_pulse (load_pulse),
    .load_idx   (load_idx)
  );

  // R7
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (parked && !pe_in) |=> parked);

  // R10
  fall_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_pulse && !$past(parked) && !parked) |=> !load_pulse);
endmodule

// File: tb/prog_fetch_seq_bench.sv
module prog_fetch_seq_bench;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pc = 1'b0;
  logic       pe = 1'b1;
  logic       cfg = 1'b0;
  logic [6:0] fetch_n;
  logic       load_pulse;
  logic [2:0] load_idx;

  prog_fetch_seq #(.SYNC_STAGES(SYNC)) u_prog_fetch_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_in      (pc),
    .pe_in      (pe),
    .cfg_valid  (cfg),
    .fetch_n    (fetch_n),
    .load_pulse (load_pulse),
    .load_idx   (load_idx)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int m_idx  = 0;
  int m_mode = 0;
  int hist[$];
  int prv    = 0;
  bit model_on = 0;
  int ld_cnt[8];

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic int total_loads();
    int s = 0;
    for (int k = 0; k < 8; k++) s += ld_cnt[k];
    return s;
  endfunction

  task automatic clear_counts();
    for (int k = 0; k < 8; k++) ld_cnt[k] = 0;
  endtask

  task automatic tick();
    int last, rise, fall, e_ld, e_li, e_f;
    @(negedge clk);
    if (model_on) begin
      last = hist[SYNC-1];
      rise = (last == 1 && prv == 0);
      fall = (last == 0 && prv == 1);
      e_ld = 0; e_li = 0;
      if (m_mode == 2) begin
        if (cfg) begin e_ld = 1; e_li = 6; end
      end else if (fall && m_idx != 7) begin
        e_ld = 1; e_li = m_idx;
      end
      if (m_mode == 0 && rise) begin
        if (pe) m_idx = (m_idx + 1) % 8;
        else begin m_idx = 7; m_mode = 1; end
      end else if (m_mode == 1 && fall) begin
        m_idx = 6; m_mode = 2;
      end else if (m_mode == 2 && rise && pe) begin
        m_idx = 7; m_mode = 0;
      end
      prv = last;
      hist.push_front(int'(pc));
      void'(hist.pop_back());
      e_f = 7'h7F;
      if (m_idx < 7) e_f = e_f & ~(1 << m_idx);
      chk("R2 fetch_n", fetch_n, e_f);
      chk("R4 load_pulse", load_pulse, e_ld);
      if (e_ld != 0) chk("R4 load_idx", load_idx, e_li);
      if (load_pulse) ld_cnt[load_idx]++;
    end
  endtask

  task automatic hold(input bit lvl, input int n);
    pc = lvl;
    repeat (n) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got 0 exp 1");
    report();
    $finish;
  end

  initial begin
    for (int k = 0; k < SYNC; k++) hist.push_back(0);
    clear_counts();
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", fetch_n, 7'h7E);
    chk("R1 reset load", load_pulse, 0);
    rst_n = 1'b1;
    model_on = 1;
    hold(0, 4);
    chk("R1 after release", fetch_n, 7'h7E);

    // Two full running cycles, cfg_valid toggled (ignored, R8)
    for (int i = 0; i < 16; i++) begin
      cfg = i[0];
      hold(1, 5);
      hold(0, 5);
    end
    cfg = 0;
    for (int k = 0; k < 7; k++) chk("R4 loads per period", ld_cnt[k], 2);
    chk("R3 idle loads", ld_cnt[7], 0);
    chk("R2 back at period 0", fetch_n, 7'h7E);

    // advance to period 3
    repeat (3) begin hold(1, 5); hold(0, 5); end
    chk("R2 period 3", fetch_n, 7'h77);
    clear_counts();

    // stop request
    pe = 0;
    hold(1, 5);
    chk("R5 break strobes", fetch_n, 7'h7F);
    hold(0, 5);
    chk("R6 parked strobes", fetch_n, 7'h3F);
    chk("R6 no load on parking", total_loads(), 0);

    repeat (2) begin hold(1, 5); hold(0, 5); end
    chk("R7 still parked", fetch_n, 7'h3F);
    chk("R7 no loads", total_loads(), 0);

    // direct configuration loads
    cfg = 1; repeat (3) tick();
    cfg = 0; repeat (2) tick();
    cfg = 1; tick();
    cfg = 0; repeat (2) tick();
    chk("R8 cfg loads", ld_cnt[6], 4);

    // resume with cfg_valid held across the rising edge
    cfg = 1; pe = 1;
    hold(1, 5);
    cfg = 0;
    chk("R9 resume to idle", fetch_n, 7'h7F);
    chk("R9 coincident cfg loads", ld_cnt[6], 7);
    hold(0, 5);
    chk("R3 idle fall no load", total_loads(), 7);
    hold(1, 5);
    chk("R9 cycle resumes", fetch_n, 7'h7E);
    hold(0, 20);
    chk("R10 single pulse per fall", ld_cnt[0], 1);

    // short programme-clock pulses
    repeat (6) begin hold(1, 1); hold(0, 1); end
    hold(0, 4);

    // stop from idle step
    while (fetch_n != 7'h7F) begin hold(1, 5); hold(0, 5); end
    pe = 0;
    hold(1, 5);
    hold(0, 5);
    chk("R6 parked from idle", fetch_n, 7'h3F);
    pe = 1;
    hold(1, 5);
    hold(0, 5);

    report();
    $finish;
  end
endmodule